// File: doc/BRIEF.md
# PCM Frame Transmitter

This block turns 32-bit words from a transmit FIFO into a serial PCM data stream. A frame lasts a programmable number of bit periods. It carries up to two channel slots, and each slot has its own enable, width and starting offset. A frame-sync pulse marks the first bit period of every frame. Data bits go out MSB first.

Software drives the block through a small register port.
- It fills the FIFO through a data register.
- It polls a can-accept status bit to know when another word fits.
- It sets the frame length and the channel layout.
- It starts the stream with three control bits: interface enable, transmit enable and standby release. All three must be set.

The bit clock is not a separate clock. It arrives as a one-cycle strobe, `bit_tick`, on the system clock, and each strobe stands for one falling edge of the bit clock.

A sync bit in the control register acts as a handshake across the bit-clock domain. The written value is first captured on a bit tick. It becomes visible to reads only after it has come back through a two-stage synchroniser. Software can therefore confirm that the bit clock is running.

Top module: `pcm_frame_tx`

## Requirements
- R1: After reset, both outputs are 0, the FIFO is empty, and the control register (address 0) reads 32'h0008_0000: only the can-accept bit 19 is set.
- R2: Running with frame-length field F in mode register (address 2) bits 15:10 gives a frame of F+1 bit ticks. `pcm_fs` is 1 for exactly the first tick of each frame and 0 otherwise.
- R3: The configuration register (address 3) holds two 16-bit channel descriptors. Channel 1 is in bits 31:16 and channel 2 in bits 15:0. Each descriptor is {extend, enable, position[9:0], width[3:0]}, so channel 1's enable is bit 30, its extend is bit 31 and its width is bits 19:16. A channel sends min(8 + width + 16*extend, 32) bits. These are the low bits of its FIFO word, MSB first.
- R4: A channel's first bit appears in the frame tick whose index equals its position field. The frame-sync tick has index 0.
- R5: A disabled channel drives nothing and takes no word from the FIFO. With both channels disabled, `pcm_dout` stays 0 and the FIFO keeps its content.
- R6: The FIFO holds 64 words, written through the data register (address 1). Control bit 19 reads 1 while at least one entry is free. A write when the FIFO is full is dropped.
- R7: If the FIFO is empty when an enabled slot starts, the slot sends zeros and the sticky underflow bit 16 of the control register is set. It stays set until a control write with bit 3 set clears it.
- R8: The stream runs only while control bits 0 (enable), 2 (transmit enable) and 25 (standby release) are all 1. Otherwise `pcm_fs` and `pcm_dout` are 0 and no word is taken.
- R9: A value written to control bit 24 reads back only after it has been captured on a bit tick and then passed through two system-clock stages. Before that, the old value is read.
- R10: If both channels start on the same tick, channel 1 sends and channel 2's slot is skipped without taking a word.
- R11: A control write with bit 3 set empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit-clock falling edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 mode, 3 channel configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pcm_dout | output | 1 | Serial PCM data |
| pcm_fs | output | 1 | Frame-sync pulse |

## Verification
The properties assume three things about the inputs:
- The configuration does not change while the stream runs.
- Every enabled slot ends inside its frame.
- A FIFO clear does not coincide with a push.

The stimulus respects all three. It stops the stream before each reconfiguration and picks slot positions and widths that fit the frame. It issues clears only while the block is idle.

The one case where slots touch is the deliberate same-start case for channel priority.

// File: rtl/pcm_frame_tx.sv
module pcm_frame_tx #(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pcm_dout,
  output logic        pcm_fs
);
  localparam int AW = $clog2(FIFO_DEPTH);

  logic        ctl_en, ctl_txon, ctl_stby, ctl_sync, uflow;
  logic [5:0]  flen;
  logic [31:0] chcfg;
  logic [31:0] mem [FIFO_DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic        sync_b, sync_r1, sync_r2;
  logic        started;
  logic [5:0]  bitidx;
  logic [31:0] sh  [2];
  logic [5:0]  rem [2];
  logic        act [2];
  logic        fs_q;

  logic        ch_en    [2];
  logic [9:0]  ch_pos   [2];
  logic [5:0]  ch_w     [2];
  logic        start_eff[2];

  wire running = ctl_en & ctl_txon & ctl_stby;
  wire full    = (count == (AW+1)'(FIFO_DEPTH));
  wire empty   = (count == '0);
  wire ctl_wr  = reg_wr && reg_addr == 2'd0;
  wire clr     = ctl_wr && reg_wdata[3];
  wire push    = reg_wr && reg_addr == 2'd1 && !full;
  wire [5:0] nxt = (!started || bitidx == flen) ? 6'd0 : bitidx + 6'd1;
  wire [31:0] head = mem[rptr];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      logic [15:0] d;
      logic [5:0]  raw;
      d         = (c == 0) ? chcfg[31:16] : chcfg[15:0];
      ch_en[c]  = d[14];
      ch_pos[c] = d[13:4];
      raw       = 6'd8 + {2'b0, d[3:0]} + (d[15] ? 6'd16 : 6'd0);
      ch_w[c]   = (raw > 6'd32) ? 6'd32 : raw;
    end
    start_eff[0] = running && bit_tick && ch_en[0] && ({4'b0, nxt} == ch_pos[0]);
    start_eff[1] = running && bit_tick && ch_en[1] && ({4'b0, nxt} == ch_pos[1]) && !start_eff[0];
  end

  wire pop = (start_eff[0] | start_eff[1]) & !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_txon <= 1'b0; ctl_stby <= 1'b0; ctl_sync <= 1'b0;
      flen <= '0; chcfg <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          ctl_en   <= reg_wdata[0];
          ctl_txon <= reg_wdata[2];
          ctl_sync <= reg_wdata[24];
          ctl_stby <= reg_wdata[25];
        end
        2'd2: flen  <= reg_wdata[15:10];
        2'd3: chcfg <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; uflow <= 1'b0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0; uflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: ;
      endcase
      if ((start_eff[0] | start_eff[1]) && empty) uflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_b <= 1'b0; sync_r1 <= 1'b0; sync_r2 <= 1'b0;
    end else begin
      if (bit_tick) sync_b <= ctl_sync;
      sync_r1 <= sync_b;
      sync_r2 <= sync_r1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0; bitidx <= '0; fs_q <= 1'b0;
    end else if (!running) begin
      started <= 1'b0; bitidx <= '0; fs_q <= 1'b0;
    end else if (bit_tick) begin
      started <= 1'b1;
      bitidx  <= nxt;
      fs_q    <= (nxt == 6'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        sh[c] <= '0; rem[c] <= '0; act[c] <= 1'b0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (!running) begin
          sh[c] <= '0; rem[c] <= '0; act[c] <= 1'b0;
        end else if (bit_tick) begin
          if (start_eff[c]) begin
            act[c] <= 1'b1;
            rem[c] <= ch_w[c] - 6'd1;
            sh[c]  <= empty ? 32'd0 : (head << (6'd32 - ch_w[c]));
          end else if (act[c]) begin
            if (rem[c] == 6'd0) act[c] <= 1'b0;
            else begin
              sh[c]  <= sh[c] << 1;
              rem[c] <= rem[c] - 6'd1;
            end
          end
        end
      end
    end
  end

  assign pcm_dout = act[0] ? sh[0][31] : (act[1] ? sh[1][31] : 1'b0);
  assign pcm_fs   = fs_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {6'b0, ctl_stby, sync_r2, 4'b0, ~full, 2'b0, uflow,
                            13'b0, ctl_txon, 1'b0, ctl_en};
      2'd2:    reg_rdata = {16'b0, flen, 10'b0};
      2'd3:    reg_rdata = chcfg;
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module pcm_frame_tx_chk #(
  parameter int FIFO_DEPTH = 64
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bit_tick,
  input logic                          reg_wr,
  input logic [1:0]                    reg_addr,
  input logic [31:0]                   reg_wdata,
  input logic [31:0]                   reg_rdata,
  input logic                          pcm_dout,
  input logic                          pcm_fs,
  input logic                          running,
  input logic                          uflow,
  input logic [5:0]                    flen,
  input logic [$clog2(FIFO_DEPTH):0]   count
);
  assert_fs_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_fs) |-> $past(bit_tick));

  assert_fs_one_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_fs && bit_tick && running && flen != 6'd0) |=> !pcm_fs);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH));

  assert_full_no_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0 && count == ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH)) |-> !reg_rdata[19]);

  assert_uflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !(reg_wr && reg_addr == 2'd0 && reg_wdata[3])) |=> uflow);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!pcm_fs && !pcm_dout));
endmodule

bind pcm_frame_tx pcm_frame_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pcm_dout(pcm_dout), .pcm_fs(pcm_fs), .running(running), .uflow(uflow),
  .flen(flen), .count(count));

// File: tb/pcm_frame_tx_tb.sv
module pcm_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        pcm_dout, pcm_fs;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] CTRL_IDLE = 32'h0200_0000;
  localparam logic [31:0] CTRL_RUN  = 32'h0200_0005;
  localparam logic [31:0] CTRL_CLR  = 32'h0200_0008;

  typedef struct packed {
    logic [5:0]  flen;
    logic        x1; logic e1; logic [9:0] p1; logic [3:0] f1;
    logic        x2; logic e2; logic [9:0] p2; logic [3:0] f2;
    logic [31:0] d1; logic [31:0] d2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{6'd31, 1'b0, 1'b1, 10'd0, 4'd8,  1'b0, 1'b1, 10'd16, 4'd8,  32'h0000A5C3, 32'h00001234},
    '{6'd31, 1'b1, 1'b1, 10'd0, 4'd8,  1'b0, 1'b0, 10'd0,  4'd0,  32'hDEADBEEF, 32'h0},
    '{6'd47, 1'b0, 1'b1, 10'd3, 4'd0,  1'b0, 1'b1, 10'd20, 4'd4,  32'h0000005A, 32'h00000ABC},
    '{6'd63, 1'b1, 1'b1, 10'd1, 4'd0,  1'b0, 1'b1, 10'd30, 4'd15, 32'h00123456, 32'h005AAAAA},
    '{6'd15, 1'b0, 1'b0, 10'd0, 4'd0,  1'b0, 1'b1, 10'd4,  4'd0,  32'h00000081, 32'h0},
    '{6'd39, 1'b1, 1'b1, 10'd5, 4'd15, 1'b0, 1'b0, 10'd0,  4'd0,  32'hC0FFEE11, 32'h0}
  };

  pcm_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pcm_dout(pcm_dout), .pcm_fs(pcm_fs));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic run_ticks(input int n, output logic [63:0] gd, output logic [63:0] gf);
    gd = '0; gf = '0;
    for (int i = 0; i < n; i++) begin
      tick();
      gd[i] = pcm_dout;
      gf[i] = pcm_fs;
    end
  endtask

  function automatic int wid(input logic [3:0] f, input logic x);
    int w = 8 + int'(f) + (x ? 16 : 0);
    return (w > 32) ? 32 : w;
  endfunction

  function automatic logic [63:0] exp_frame(input vec_t v);
    logic [63:0] e = '0;
    int w1 = wid(v.f1, v.x1);
    int w2 = wid(v.f2, v.x2);
    for (int i = 0; i <= int'(v.flen); i++) begin
      if (v.e1 && i >= int'(v.p1) && i < int'(v.p1) + w1)
        e[i] = v.d1[w1 - 1 - (i - int'(v.p1))];
      else if (v.e2 && i >= int'(v.p2) && i < int'(v.p2) + w2)
        e[i] = v.d2[w2 - 1 - (i - int'(v.p2))];
    end
    return e;
  endfunction

  function automatic logic [63:0] byte_frame(input logic [7:0] b, input int at);
    logic [63:0] e = '0;
    for (int i = 0; i < 8; i++) e[at + i] = b[7 - i];
    return e;
  endfunction

  function automatic logic [31:0] word_of(input logic [63:0] g);
    logic [31:0] w;
    for (int j = 0; j < 32; j++) w[31 - j] = g[j];
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] gd, gf, fs_exp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, r);
    chk(r == 32'h0008_0000, "R1 ctrl", 64'(r), 64'h0008_0000);
    chk(!pcm_dout && !pcm_fs, "R1 outputs", {pcm_dout, pcm_fs}, 64'h0);

    // R2 R3 R4 table of frames
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      wr(2'd0, CTRL_IDLE);
      wr(2'd0, CTRL_CLR);
      wr(2'd2, 32'(v.flen) << 10);
      wr(2'd3, {v.x1, v.e1, v.p1, v.f1, v.x2, v.e2, v.p2, v.f2});
      if (v.e1) wr(2'd1, v.d1);
      if (v.e2) wr(2'd1, v.d2);
      wr(2'd0, CTRL_RUN);
      run_ticks(int'(v.flen) + 1, gd, gf);
      chk(gd == exp_frame(v), "R3 R4 frame data", gd, exp_frame(v));
      chk(gf == 64'h1, "R2 frame sync", gf, 64'h1);
      rd(2'd0, r);
      chk(r[16] == 1'b0, "R7 no underflow", 64'(r[16]), 64'h0);
    end

    // R8 gating on standby release
    wr(2'd0, CTRL_IDLE);
    wr(2'd0, CTRL_CLR);
    wr(2'd2, 32'd7 << 10);
    wr(2'd3, 32'h4000_0000);
    wr(2'd1, 32'h96);
    wr(2'd0, 32'h0000_0005);
    run_ticks(10, gd, gf);
    chk(gd == 0 && gf == 0, "R8 held in standby", gd | gf, 64'h0);
    wr(2'd0, CTRL_RUN);
    run_ticks(8, gd, gf);
    chk(gd == byte_frame(8'h96, 0), "R8 word kept for run", gd, byte_frame(8'h96, 0));

    // R5 disabled channels, R2 frame period
    wr(2'd0, CTRL_IDLE);
    wr(2'd0, CTRL_CLR);
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h5B);
    wr(2'd0, CTRL_RUN);
    run_ticks(16, gd, gf);
    fs_exp = 64'h101;
    chk(gf == fs_exp, "R2 two frames", gf, fs_exp);
    chk(gd == 0, "R5 silent", gd, 64'h0);
    wr(2'd0, CTRL_IDLE);
    wr(2'd3, 32'h4000_0000);
    wr(2'd0, CTRL_RUN);
    run_ticks(8, gd, gf);
    chk(gd == byte_frame(8'h5B, 0), "R5 word not taken", gd, byte_frame(8'h5B, 0));

    // R11 clear, R7 underflow
    wr(2'd0, CTRL_IDLE);
    wr(2'd0, CTRL_CLR);
    wr(2'd1, 32'h77);
    wr(2'd0, CTRL_CLR);
    wr(2'd0, CTRL_RUN);
    run_ticks(8, gd, gf);
    chk(gd == 0, "R11 cleared FIFO sends zeros", gd, 64'h0);
    rd(2'd0, r);
    chk(r[16] == 1'b1, "R7 underflow set", 64'(r[16]), 64'h1);
    wr(2'd0, CTRL_IDLE);
    rd(2'd0, r);
    chk(r[16] == 1'b1, "R7 underflow sticky", 64'(r[16]), 64'h1);
    wr(2'd0, CTRL_CLR);
    rd(2'd0, r);
    chk(r[16] == 1'b0, "R7 underflow cleared", 64'(r[16]), 64'h0);

    // R10 same start, channel 1 wins
    wr(2'd0, CTRL_IDLE);
    wr(2'd0, CTRL_CLR);
    wr(2'd2, 32'd15 << 10);
    wr(2'd3, {1'b0, 1'b1, 10'd2, 4'd0, 1'b0, 1'b1, 10'd2, 4'd0});
    wr(2'd1, 32'hA5);
    wr(2'd1, 32'h3C);
    wr(2'd0, CTRL_RUN);
    run_ticks(32, gd, gf);
    chk(gd == (byte_frame(8'hA5, 2) | byte_frame(8'h3C, 18)), "R10 priority",
        gd, byte_frame(8'hA5, 2) | byte_frame(8'h3C, 18));
    rd(2'd0, r);
    chk(r[16] == 1'b0, "R10 no extra pop", 64'(r[16]), 64'h0);

    // R6 full FIFO
    wr(2'd0, CTRL_IDLE);
    wr(2'd0, CTRL_CLR);
    wr(2'd2, 32'd31 << 10);
    wr(2'd3, 32'hC008_0000);
    for (int i = 0; i < 64; i++) wr(2'd1, 32'h1000_0000 + 32'(i));
    rd(2'd0, r);
    chk(r[19] == 1'b0, "R6 full flag", 64'(r[19]), 64'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, CTRL_RUN);
    for (int f = 0; f < 64; f++) begin
      run_ticks(32, gd, gf);
      if (f == 0) begin
        chk(word_of(gd) == 32'h1000_0000, "R6 first word", 64'(word_of(gd)), 64'h1000_0000);
        rd(2'd0, r);
        chk(r[19] == 1'b1, "R6 accept after pop", 64'(r[19]), 64'h1);
      end
      if (f == 63)
        chk(word_of(gd) == 32'h1000_003F, "R6 last word", 64'(word_of(gd)), 64'h1000_003F);
    end
    run_ticks(32, gd, gf);
    chk(gd == 0, "R6 overflow write dropped", gd, 64'h0);
    rd(2'd0, r);
    chk(r[16] == 1'b1, "R7 underflow after drain", 64'(r[16]), 64'h1);

    // R9 sync handshake
    wr(2'd0, 32'h0100_0000);
    rd(2'd0, r);
    chk(r[24] == 1'b0, "R9 not yet", 64'(r[24]), 64'h0);
    repeat (2) @(negedge clk);
    rd(2'd0, r);
    chk(r[24] == 1'b0, "R9 waits for tick", 64'(r[24]), 64'h0);
    tick();
    @(posedge clk);
    #1 chk(reg_rdata[24] == 1'b0, "R9 one stage", 64'(reg_rdata[24]), 64'h0);
    @(posedge clk);
    #1 chk(reg_rdata[24] == 1'b1, "R9 returned", 64'(reg_rdata[24]), 64'h1);
    wr(2'd0, 32'h0);
    tick();
    repeat (2) @(posedge clk);
    #1 chk(reg_rdata[24] == 1'b0, "R9 cleared back", 64'(reg_rdata[24]), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule